// File: doc/BRIEF.md
# Cumulative Reset Cause Log

This block keeps a small retained status word that tells software why the chip last restarted or woke from its off state. Each reset or wake source delivers a one-cycle pulse. The pulse sets that source's flag in the word. There are four reset sources: the external reset pin, the watchdog, a software-requested reset and a processor lockup. There are five wake sources: a GPIO detect, the low-power analog comparator, entry into the debug interface, an NFC field and a valid VBUS level.

Flags are never overwritten by later resets. They pile up until software clears them. Software clears flags one at a time by writing 1 to each flag it wants to drop. The only input that wipes the whole word is the cold reset, which is driven by the power-on or brownout generator. So when software finds every flag at zero after a restart, the cause was a power-on or brownout event.

Two source pulses are filtered by context. A lockup pulse has no effect while the debug interface is active. A watchdog pulse has no effect while the system is in its off state.

Top module: `reset_cause_log`

## Requirements
- R1: After the cold reset is released, the read word is 0x00000000.
- R2: A pin reset pulse sets bit 0 and a soft reset pulse sets bit 2. The change shows on the read word after the next rising clock edge.
- R3: A watchdog pulse sets bit 1 while sysOff is low. While sysOff is high, a watchdog pulse changes nothing.
- R4: A lockup pulse sets bit 3 while debugMode is low. While debugMode is high, a lockup pulse changes nothing.
- R5: Each wake pulse sets its own bit: GPIO detect sets bit 16, analog comparator sets bit 17, debug entry sets bit 18, NFC field sets bit 19 and VBUS sets bit 20.
- R6: Flags accumulate. A set flag stays set through any number of later source pulses, until it is cleared by a write or by the cold reset.
- R7: A cycle with wrEn high clears every defined bit whose wrData bit is 1. Defined bits whose wrData bit is 0 are left alone. The result is visible after that clock edge.
- R8: If a clearing write and a source pulse hit the same bit in the same cycle, the bit ends up set.
- R9: Bits 4 to 15 and 21 to 31 always read as 0, whatever is written to them.
- R10: Driving coldRstN low clears every flag at once, without waiting for a clock edge. No other input clears more than the bits written with 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock of the retained domain |
| coldRstN | input | 1 | Power-on/brownout reset, active low, asynchronous; clears the log |
| pinRstPulse | input | 1 | One-cycle pulse: pin reset occurred |
| dogRstPulse | input | 1 | One-cycle pulse: watchdog reset occurred |
| softRstPulse | input | 1 | One-cycle pulse: software-requested reset occurred |
| lockupPulse | input | 1 | One-cycle pulse: processor lockup reset occurred |
| wakeGpio | input | 1 | One-cycle pulse: wake by GPIO detect |
| wakeAnaComp | input | 1 | One-cycle pulse: wake by low-power analog comparator |
| wakeDebug | input | 1 | One-cycle pulse: wake by debug interface entry |
| wakeNfc | input | 1 | One-cycle pulse: wake by NFC field |
| wakeVbus | input | 1 | One-cycle pulse: wake by VBUS entering its valid range |
| sysOff | input | 1 | High while the system is in its off state |
| debugMode | input | 1 | High while the debug interface is active |
| wrEn | input | 1 | Software write strobe for the clear operation |
| wrData | input | DATA_W | Write-1-to-clear mask |
| rdData | output | DATA_W | Current cause word |

## Verification
The bench uses the default DATA_W of 32. At that width every reserved gap is present: the bits between the lockup flag and the first wake flag, and the bits above the VBUS flag. Writing all ones and the reserved-only pattern 0xFFE0FFF0 therefore shows that those bits neither hold data nor disturb the defined flags. The same width also lets one vector drive every source together with a clear of bit 0, which exercises the set-over-clear rule while all nine flags are active at once.

// File: rtl/reset_cause_pkg.sv
package reset_cause_pkg;

  // Number of distinct causes that are logged.
  localparam int CAUSE_CNT = 9;

  // Cause indices (order of the internal flag vector).
  localparam int IDX_PIN    = 0;
  localparam int IDX_DOG    = 1;
  localparam int IDX_SOFT   = 2;
  localparam int IDX_LOCKUP = 3;
  localparam int IDX_GPIO   = 4;
  localparam int IDX_ANA    = 5;
  localparam int IDX_DBG    = 6;
  localparam int IDX_NFC    = 7;
  localparam int IDX_VBUS   = 8;

  // Bit position of each cause in the software-visible word.
  localparam int CAUSE_POS [CAUSE_CNT] = '{0, 1, 2, 3, 16, 17, 18, 19, 20};

  // Highest bit position used; the word must be wider than this.
  localparam int TOP_POS = 20;

  // Strobes from control to datapath, one pair per cause.
  typedef struct packed {
    logic [CAUSE_CNT-1:0] setFlag;
    logic [CAUSE_CNT-1:0] clrFlag;
  } cause_strobe_t;

endpackage

// File: rtl/reset_cause_ctrl.sv
module reset_cause_ctrl
  import reset_cause_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              pinRstPulse,
  input  logic              dogRstPulse,
  input  logic              softRstPulse,
  input  logic              lockupPulse,
  input  logic              wakeGpio,
  input  logic              wakeAnaComp,
  input  logic              wakeDebug,
  input  logic              wakeNfc,
  input  logic              wakeVbus,
  input  logic              sysOff,
  input  logic              debugMode,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output cause_strobe_t     strobe
);

  logic [CAUSE_CNT-1:0] rawPulse;
  logic [CAUSE_CNT-1:0] allowMask;

  // Gather the source pulses into cause order.
  always_comb begin
    rawPulse             = '0;
    rawPulse[IDX_PIN]    = pinRstPulse;
    rawPulse[IDX_DOG]    = dogRstPulse;
    rawPulse[IDX_SOFT]   = softRstPulse;
    rawPulse[IDX_LOCKUP] = lockupPulse;
    rawPulse[IDX_GPIO]   = wakeGpio;
    rawPulse[IDX_ANA]    = wakeAnaComp;
    rawPulse[IDX_DBG]    = wakeDebug;
    rawPulse[IDX_NFC]    = wakeNfc;
    rawPulse[IDX_VBUS]   = wakeVbus;
  end

  // Context filter: watchdog cannot fire in the off state,
  // lockup is disregarded while the debugger is attached.
  always_comb begin
    allowMask             = '1;
    allowMask[IDX_DOG]    = ~sysOff;
    allowMask[IDX_LOCKUP] = ~debugMode;
  end

  // Decode the write word into per-cause clear strobes; reserved
  // bit positions simply have no strobe and are dropped here.
  always_comb begin
    strobe.setFlag = rawPulse & allowMask;
    strobe.clrFlag = '0;
    for (int k = 0; k < CAUSE_CNT; k++) begin
      strobe.clrFlag[k] = wrEn & wrData[CAUSE_POS[k]];
    end
  end

endmodule

// File: rtl/reset_cause_dp.sv
module reset_cause_dp
  import reset_cause_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              coldRstN,
  input  cause_strobe_t     strobe,
  output logic [DATA_W-1:0] rdWord
);

  logic [CAUSE_CNT-1:0] flagQ;

  // One retained flag per cause; a set strobe outranks a clear.
  for (genvar k = 0; k < CAUSE_CNT; k++) begin : g_flag
    always_ff @(posedge clk or negedge coldRstN) begin
      if (!coldRstN) begin
        flagQ[k] <= 1'b0;
      end else if (strobe.setFlag[k]) begin
        flagQ[k] <= 1'b1;
      end else if (strobe.clrFlag[k]) begin
        flagQ[k] <= 1'b0;
      end
    end
  end

  // Spread flags onto their word positions; all other bits read zero.
  always_comb begin
    rdWord = '0;
    for (int k = 0; k < CAUSE_CNT; k++) begin
      rdWord[CAUSE_POS[k]] = flagQ[k];
    end
  end

endmodule

// File: rtl/reset_cause_log.sv
module reset_cause_log
  import reset_cause_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              coldRstN,
  input  logic              pinRstPulse,
  input  logic              dogRstPulse,
  input  logic              softRstPulse,
  input  logic              lockupPulse,
  input  logic              wakeGpio,
  input  logic              wakeAnaComp,
  input  logic              wakeDebug,
  input  logic              wakeNfc,
  input  logic              wakeVbus,
  input  logic              sysOff,
  input  logic              debugMode,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  localparam int MIN_W = TOP_POS + 1;

  cause_strobe_t strobe;

  reset_cause_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .pinRstPulse (pinRstPulse),
    .dogRstPulse (dogRstPulse),
    .softRstPulse(softRstPulse),
    .lockupPulse (lockupPulse),
    .wakeGpio    (wakeGpio),
    .wakeAnaComp (wakeAnaComp),
    .wakeDebug   (wakeDebug),
    .wakeNfc     (wakeNfc),
    .wakeVbus    (wakeVbus),
    .sysOff      (sysOff),
    .debugMode   (debugMode),
    .wrEn        (wrEn),
    .wrData      (wrData),
    .strobe      (strobe)
  );

  reset_cause_dp #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .coldRstN(coldRstN),
    .strobe  (strobe),
    .rdWord  (rdData)
  );

  initial begin
    if (DATA_W < MIN_W) $display("reset_cause_log: DATA_W below %0d", MIN_W);
  end

endmodule

// File: rtl/reset_cause_chk.sv
module reset_cause_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              coldRstN,
  input logic              pinRstPulse,
  input logic              dogRstPulse,
  input logic              lockupPulse,
  input logic              wakeVbus,
  input logic              sysOff,
  input logic              debugMode,
  input logic              wrEn,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] reservedMask;
  always_comb begin
    reservedMask = '1;
    reservedMask[3:0]   = 4'h0;
    reservedMask[20:16] = 5'h00;
  end

  // R9
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!coldRstN)
    (rdData & reservedMask) == {DATA_W{1'b0}});

  // R2
  pin_sets_chk: assert property (@(posedge clk) disable iff (!coldRstN)
    pinRstPulse |=> rdData[0]);

  // R3
  dog_gated_chk: assert property (@(posedge clk) disable iff (!coldRstN)
    (!rdData[1] && (!dogRstPulse || sysOff)) |=> !rdData[1]);

  // R4
  lockup_gated_chk: assert property (@(posedge clk) disable iff (!coldRstN)
    (!rdData[3] && (!lockupPulse || debugMode)) |=> !rdData[3]);

  // R5
  vbus_sets_chk: assert property (@(posedge clk) disable iff (!coldRstN)
    wakeVbus |=> rdData[20]);

  // R6
  sticky_chk: assert property (@(posedge clk) disable iff (!coldRstN)
    1'b1 |=> ((~rdData & $past(rdData) &
               ~($past(wrEn) ? $past(wrData) : {DATA_W{1'b0}})) == {DATA_W{1'b0}}));

  // R7
  clear_bit0_chk: assert property (@(posedge clk) disable iff (!coldRstN)
    (wrEn && wrData[0] && !pinRstPulse) |=> !rdData[0]);

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!coldRstN)
    (pinRstPulse && wrEn && wrData[0]) |=> rdData[0]);

endmodule

bind reset_cause_log reset_cause_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .coldRstN   (coldRstN),
  .pinRstPulse(pinRstPulse),
  .dogRstPulse(dogRstPulse),
  .lockupPulse(lockupPulse),
  .wakeVbus   (wakeVbus),
  .sysOff     (sysOff),
  .debugMode  (debugMode),
  .wrEn       (wrEn),
  .wrData     (wrData),
  .rdData     (rdData)
);

// File: tb/reset_cause_log_bench.sv
module reset_cause_log_bench;

  localparam int DATA_W = 32;

  logic clk = 1'b0;
  logic coldRstN = 1'b0;
  logic pinRstPulse = 1'b0, dogRstPulse = 1'b0, softRstPulse = 1'b0, lockupPulse = 1'b0;
  logic wakeGpio = 1'b0, wakeAnaComp = 1'b0, wakeDebug = 1'b0, wakeNfc = 1'b0, wakeVbus = 1'b0;
  logic sysOff = 1'b0, debugMode = 1'b0, wrEn = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  reset_cause_log #(.DATA_W(DATA_W)) u_reset_cause_log (
    .clk(clk), .coldRstN(coldRstN),
    .pinRstPulse(pinRstPulse), .dogRstPulse(dogRstPulse),
    .softRstPulse(softRstPulse), .lockupPulse(lockupPulse),
    .wakeGpio(wakeGpio), .wakeAnaComp(wakeAnaComp), .wakeDebug(wakeDebug),
    .wakeNfc(wakeNfc), .wakeVbus(wakeVbus),
    .sysOff(sysOff), .debugMode(debugMode),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData)
  );

  // src bits: [0]pin [1]dog [2]soft [3]lockup [4]gpio [5]anacomp [6]debug [7]nfc [8]vbus
  typedef struct packed {
    logic [8:0]  src;
    logic        off;
    logic        dbgm;
    logic        we;
    logic [31:0] wd;
    logic [31:0] exp;
  } vec_t;

  localparam int NVEC = 15;
  localparam vec_t VECS [NVEC] = '{
    '{9'h001, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_0001}, // R2 pin
    '{9'h004, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_0005}, // R2 soft, R6
    '{9'h002, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_0007}, // R3 dog allowed
    '{9'h008, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_000F}, // R4 lockup allowed
    '{9'h000, 1'b0, 1'b0, 1'b1, 32'h0000_0005, 32'h0000_000A}, // R7 partial clear
    '{9'h010, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 32'h0001_000A}, // R5 gpio
    '{9'h060, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 32'h0007_000A}, // R5 anacomp+debug
    '{9'h180, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 32'h001F_000A}, // R5 nfc+vbus
    '{9'h000, 1'b0, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000}, // R7 clear all, R9
    '{9'h002, 1'b1, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_0000}, // R3 dog ignored in off
    '{9'h008, 1'b0, 1'b1, 1'b0, 32'h0000_0000, 32'h0000_0000}, // R4 lockup ignored in debug
    '{9'h001, 1'b0, 1'b0, 1'b1, 32'h0000_0001, 32'h0000_0001}, // R8 set beats clear
    '{9'h000, 1'b0, 1'b0, 1'b1, 32'hFFE0_FFF0, 32'h0000_0001}, // R9 reserved-only write
    '{9'h000, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_0001}, // R6 idle holds
    '{9'h1FF, 1'b0, 1'b0, 1'b1, 32'h0000_0001, 32'h001F_000F}  // R8 R6 all sources
  };

  task automatic check(input string req, input int idx, input logic [31:0] expv);
    testsRun++;
    if (rdData !== expv) begin
      testsFailed++;
      $display("FAIL %s step %0d: rdData=%08h expected=%08h", req, idx, rdData, expv);
    end
  endtask

  task automatic applyVec(input vec_t v);
    pinRstPulse  = v.src[0];
    dogRstPulse  = v.src[1];
    softRstPulse = v.src[2];
    lockupPulse  = v.src[3];
    wakeGpio     = v.src[4];
    wakeAnaComp  = v.src[5];
    wakeDebug    = v.src[6];
    wakeNfc      = v.src[7];
    wakeVbus     = v.src[8];
    sysOff       = v.off;
    debugMode    = v.dbgm;
    wrEn         = v.we;
    wrData       = v.wd;
  endtask

  localparam vec_t IDLE = '{9'h000, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0};

  initial begin
    repeat (3) @(negedge clk);
    coldRstN = 1'b1;
    @(negedge clk);
    check("R1", -1, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      applyVec(VECS[i]);
      @(negedge clk);
      applyVec(IDLE);
      check("VEC", i, VECS[i].exp);
    end

    // R10: asynchronous clear from cold reset, mid-cycle
    #3 coldRstN = 1'b0;
    #1 check("R10", 100, 32'h0);
    @(negedge clk);
    coldRstN = 1'b1;
    @(negedge clk);
    check("R10", 101, 32'h0);

    // R1 style: log works again after cold reset, and VBUS alone
    applyVec('{9'h100, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0});
    @(negedge clk);
    applyVec(IDLE);
    check("R5", 102, 32'h0010_0000);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule